// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block drives an external analog-to-digital converter through a programmable scan of multiplexed input channels. Software uses a 16-bit write bus to set the scan window (a first and a last channel), to load a per-channel range entry (gain code, unipolar flag, differential flag), and to set a control word. The control word picks which sources may start a conversion: a write to the trigger address, a tick from an external pacer counter (optionally qualified by a gate pin), or a rising edge on an external trigger pin. It also selects the pacer clock source, which is only passed out to the pacer.

Each conversion is a start/done handshake with the converter. The sequencer presents the current channel and its range entry, pulses a start strobe, and waits for done. The 12-bit result is then emitted as a 16-bit sample whose top nibble names the channel it was taken from. The channel pointer then moves to the next channel, skipping one input after a differential channel, and returns to the first channel after the last.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, convStart, sampleValid, convChan, convRange and pacerExtClk are all zero.
- R2: A write to address 2 loads the first channel from data bits 7:0 and the last channel from bits 15:8; from the next cycle convChan equals the first channel.
- R3: A write to address 1 stores data bits 5:0 as the range entry of the first channel of the most recent mux write; convRange always shows the entry of the channel on convChan.
- R4: Bit 5 of a range entry marks a differential channel; a range write aimed at an odd channel stores bit 5 as 0.
- R5: One cycle after convDone is seen during a conversion, sampleValid is high for one cycle and sampleData holds the channel number of that conversion in bits 15:12 and convData in bits 11:0.
- R6: After each completed conversion the pointer moves to the next channel modulo 16, and from the last channel it returns to the first, also when the window wraps past channel 15.
- R7: After a completed conversion on a differential channel the pointer moves up by two, and returns to the first channel when the skipped channel is the last one.
- R8: With control bit 0 set, a write to address 0 raises convStart for exactly one cycle, starting the cycle after the write; with bit 0 clear such a write starts nothing.
- R9: With control bit 1 set, a pacerTick starts a conversion; when control bit 3 is also set, the tick starts one only while extGate is high.
- R10: With control bit 2 set, a rising edge of extTrig starts a conversion; holding extTrig high does not start another, and with bit 2 clear an edge starts nothing.
- R11: Any trigger that arrives between convStart and convDone is ignored, and convChan changes only on convDone or a mux write.
- R12: pacerExtClk follows control bit 6 from the cycle after a control write (0 internal reference, 1 external input).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Write address: 0 trigger, 1 range, 2 mux, 3 control |
| busWrData | input | 16 | Write data |
| pacerTick | input | 1 | One-cycle tick from the pacer counter |
| extTrig | input | 1 | External trigger pin |
| extGate | input | 1 | External gate pin qualifying pacer ticks |
| convDone | input | 1 | Converter finished |
| convData | input | 12 | Converter result |
| convStart | output | 1 | One-cycle conversion start |
| convChan | output | 4 | Channel presented to the multiplexer |
| convRange | output | 6 | Range entry of convChan |
| pacerExtClk | output | 1 | Pacer clock source select |
| sampleValid | output | 1 | Sample output strobe |
| sampleData | output | 16 | Channel tag and result |

## Verification
The assertions watch on every cycle that a start strobe lasts one cycle and never occurs while a conversion is outstanding, that a completed conversion yields a sample carrying the converter's result, that a mux write repositions the pointer, that an odd channel never shows a differential range entry, and that the clock-select output follows the control write. Scan order across the window, the wrap past channel 15, the two-channel step of differential channels, the channel tags, and the qualification of each trigger source by its enable and by the gate can only be shown by the bench's directed scenarios, which compare whole sample sequences against orders worked out from the requirements.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int RANGE_W = 6;
  localparam int DIFF_BIT = 5;

  localparam logic [1:0] ADDR_TRIG  = 2'd0;
  localparam logic [1:0] ADDR_RANGE = 2'd1;
  localparam logic [1:0] ADDR_MUX   = 2'd2;
  localparam logic [1:0] ADDR_CTRL  = 2'd3;

  localparam int CB_SW     = 0;
  localparam int CB_PACER  = 1;
  localparam int CB_EXT    = 2;
  localparam int CB_GATE   = 3;
  localparam int CB_CLKSEL = 6;

  typedef struct packed {
    logic muxWr;
    logic rangeWr;
    logic startConv;
    logic doneAccept;
  } seq_strobe_t;

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              pacerTick,
  input  logic              extTrig,
  input  logic              extGate,
  input  logic              convDone,
  output seq_strobe_t       strobes,
  output logic              convStart,
  output logic              busy,
  output logic              pacerExtClk
);

  logic swEn, pacerEn, extEn, gateEn;
  logic extPrev;
  logic swTrig, pacerTrig, extTrigHit, anyTrig;
  logic ctrlWr;
  logic unusedCtrlBits;

  assign unusedCtrlBits = ^{busWrData[DATA_W-1:CB_CLKSEL+1], busWrData[CB_CLKSEL-1:CB_GATE+1]};

  assign ctrlWr     = busWrEn && (busAddr == ADDR_CTRL);
  assign swTrig     = busWrEn && (busAddr == ADDR_TRIG) && swEn;
  assign pacerTrig  = pacerTick && pacerEn && (!gateEn || extGate);
  assign extTrigHit = extEn && extTrig && !extPrev;
  assign anyTrig    = swTrig || pacerTrig || extTrigHit;

  always_comb begin
    strobes.muxWr      = busWrEn && (busAddr == ADDR_MUX);
    strobes.rangeWr    = busWrEn && (busAddr == ADDR_RANGE);
    strobes.startConv  = anyTrig && !busy;
    strobes.doneAccept = convDone && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swEn        <= 1'b0;
      pacerEn     <= 1'b0;
      extEn       <= 1'b0;
      gateEn      <= 1'b0;
      pacerExtClk <= 1'b0;
    end else if (ctrlWr) begin
      swEn        <= busWrData[CB_SW];
      pacerEn     <= busWrData[CB_PACER];
      extEn       <= busWrData[CB_EXT];
      gateEn      <= busWrData[CB_GATE];
      pacerExtClk <= busWrData[CB_CLKSEL];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      convStart <= 1'b0;
      extPrev   <= 1'b0;
    end else begin
      extPrev   <= extTrig;
      convStart <= strobes.startConv;
      if (strobes.startConv)
        busy <= 1'b1;
      else if (strobes.doneAccept)
        busy <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_scan_datapath.sv
module adc_scan_datapath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 12,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int TAG_W = DATA_W - RES_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  busWrData,
  input  seq_strobe_t        strobes,
  input  logic [RES_W-1:0]   convData,
  output logic [CH_W-1:0]    convChan,
  output logic [RANGE_W-1:0] convRange,
  output logic               sampleValid,
  output logic [DATA_W-1:0]  sampleData
);

  logic [CH_W-1:0]    firstCh, lastCh, curCh, latchCh;
  logic [RANGE_W-1:0] rangeTab [NUM_CH];
  logic [RANGE_W-1:0] rangeWrVal;
  logic [CH_W-1:0]    plusOne, plusTwo, nextCh;
  logic               isDiff, atEnd;
  logic [TAG_W-1:0]   tagVal;
  logic               unusedDpBits;

  assign unusedDpBits = ^{busWrData[DATA_W-1:8+CH_W], busWrData[7:RANGE_W]};

  function automatic logic [CH_W-1:0] chAdd(input logic [CH_W-1:0] c, input int step);
    int s;
    s = int'(c) + step;
    if (s >= NUM_CH) s = s - NUM_CH;
    return CH_W'(s);
  endfunction

  // odd channels cannot be differential: strip the flag
  always_comb begin
    rangeWrVal = busWrData[RANGE_W-1:0];
    if (firstCh[0]) rangeWrVal[DIFF_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) rangeTab[i] <= '0;
    end else if (strobes.rangeWr) begin
      for (int i = 0; i < NUM_CH; i++)
        if (firstCh == CH_W'(i)) rangeTab[i] <= rangeWrVal;
    end
  end

  assign convRange = rangeTab[curCh];
  assign convChan  = curCh;

  assign isDiff  = convRange[DIFF_BIT];
  assign plusOne = chAdd(curCh, 1);
  assign plusTwo = chAdd(curCh, 2);
  assign atEnd   = (curCh == lastCh) || (isDiff && (plusOne == lastCh));
  assign nextCh  = atEnd ? firstCh : (isDiff ? plusTwo : plusOne);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstCh <= '0;
      lastCh  <= '0;
      curCh   <= '0;
      latchCh <= '0;
    end else begin
      if (strobes.startConv) latchCh <= curCh;
      if (strobes.muxWr) begin
        firstCh <= busWrData[CH_W-1:0];
        lastCh  <= busWrData[8+CH_W-1:8];
        curCh   <= busWrData[CH_W-1:0];
      end else if (strobes.doneAccept) begin
        curCh <= nextCh;
      end
    end
  end

  generate
    if (CH_W < TAG_W) begin : g_tagPad
      assign tagVal = {{(TAG_W-CH_W){1'b0}}, latchCh};
    end else begin : g_tagFull
      assign tagVal = latchCh[TAG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleValid <= 1'b0;
      sampleData  <= '0;
    end else begin
      sampleValid <= strobes.doneAccept;
      if (strobes.doneAccept) sampleData <= {tagVal, convData};
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 12,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [1:0]         busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               pacerTick,
  input  logic               extTrig,
  input  logic               extGate,
  input  logic               convDone,
  input  logic [RES_W-1:0]   convData,
  output logic               convStart,
  output logic [CH_W-1:0]    convChan,
  output logic [RANGE_W-1:0] convRange,
  output logic               pacerExtClk,
  output logic               sampleValid,
  output logic [DATA_W-1:0]  sampleData
);

  seq_strobe_t strobes;
  logic        busy;

  adc_scan_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .pacerTick(pacerTick), .extTrig(extTrig),
    .extGate(extGate), .convDone(convDone), .strobes(strobes),
    .convStart(convStart), .busy(busy), .pacerExtClk(pacerExtClk)
  );

  adc_scan_datapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWrData(busWrData), .strobes(strobes),
    .convData(convData), .convChan(convChan), .convRange(convRange),
    .sampleValid(sampleValid), .sampleData(sampleData)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int RES_W  = 12,
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [1:0]         busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic               convDone,
  input logic [RES_W-1:0]   convData,
  input logic               convStart,
  input logic               busy,
  input logic [CH_W-1:0]    convChan,
  input logic [RANGE_W-1:0] convRange,
  input logic               pacerExtClk,
  input logic               sampleValid,
  input logic [DATA_W-1:0]  sampleData
);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !convStart);

  assert_sample_follows_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && busy) |=> sampleValid);

  assert_sample_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleData[RES_W-1:0] == $past(convData)));

  assert_mux_reposition_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MUX) |=> (convChan == $past(busWrData[CH_W-1:0])));

  assert_odd_not_diff_R4: assert property (@(posedge clk) disable iff (!rstN)
    convChan[0] |-> !convRange[DIFF_BIT]);

  assert_clk_select_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CTRL) |=> (pacerExtClk == $past(busWrData[CB_CLKSEL])));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
  .convDone(convDone), .convData(convData), .convStart(convStart), .busy(busy),
  .convChan(convChan), .convRange(convRange), .pacerExtClk(pacerExtClk),
  .sampleValid(sampleValid), .sampleData(sampleData)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        pacerTick = 1'b0;
  logic        extTrig = 1'b0;
  logic        extGate = 1'b0;
  logic        convDone = 1'b0;
  logic [11:0] convData = '0;
  logic        convStart;
  logic [3:0]  convChan;
  logic [5:0]  convRange;
  logic        pacerExtClk;
  logic        sampleValid;
  logic [15:0] sampleData;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .pacerTick(pacerTick), .extTrig(extTrig), .extGate(extGate), .convDone(convDone),
    .convData(convData), .convStart(convStart), .convChan(convChan), .convRange(convRange),
    .pacerExtClk(pacerExtClk), .sampleValid(sampleValid), .sampleData(sampleData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic pulseDone(input logic [11:0] d);
    @(negedge clk);
    convDone = 1'b1; convData = d;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    pacerTick = 1'b1;
    @(negedge clk);
    pacerTick = 1'b0;
  endtask

  task automatic swConvert(input string req, input logic [3:0] expCh, input logic [11:0] d);
    chk(req, convChan, expCh);
    wr(2'd0, 16'h0);
    chk("R8 start", convStart, 1'b1);
    pulseDone(d);
    chk("R5 valid", sampleValid, 1'b1);
    chk(req, sampleData, {expCh, d});
    @(negedge clk);
    chk("R5 one cycle", sampleValid, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 convStart", convStart, 0);
    chk("R1 sampleValid", sampleValid, 0);
    chk("R1 convChan", convChan, 0);
    chk("R1 convRange", convRange, 0);
    chk("R1 pacerExtClk", pacerExtClk, 0);
  endtask

  task automatic t_mux();
    wr(2'd2, 16'h0503);
    chk("R2 first", convChan, 4'd3);
  endtask

  task automatic t_range();
    wr(2'd2, 16'h0303); wr(2'd1, 16'h0013);
    chk("R3 entry", convRange, 6'h13);
    wr(2'd2, 16'h0505); wr(2'd1, 16'h0021);
    chk("R4 odd diff", convRange, 6'h01);
    wr(2'd2, 16'h0404); wr(2'd1, 16'h0024);
    chk("R4 even diff", convRange, 6'h24);
    wr(2'd2, 16'h0303);
    chk("R3 kept", convRange, 6'h13);
  endtask

  task automatic t_scan();
    wr(2'd3, 16'h0001);
    wr(2'd2, 16'h0A08);
    swConvert("R6 scan", 4'd8, 12'h111);
    swConvert("R6 scan", 4'd9, 12'h222);
    swConvert("R6 scan", 4'd10, 12'h333);
    swConvert("R6 wrap", 4'd8, 12'h444);
    wr(2'd2, 16'h010E);
    swConvert("R6 modulo", 4'd14, 12'hABC);
    swConvert("R6 modulo", 4'd15, 12'h0F0);
    swConvert("R6 modulo", 4'd0, 12'hFFF);
    swConvert("R6 modulo", 4'd1, 12'h001);
    swConvert("R6 modulo", 4'd14, 12'h555);
  endtask

  task automatic t_diff();
    wr(2'd2, 16'h0704);
    swConvert("R7 diff", 4'd4, 12'h100);
    swConvert("R7 diff", 4'd6, 12'h200);
    swConvert("R7 diff", 4'd7, 12'h300);
    swConvert("R7 diff", 4'd4, 12'h400);
    wr(2'd2, 16'h0504);
    swConvert("R7 pair end", 4'd4, 12'h010);
    swConvert("R7 pair end", 4'd4, 12'h020);
  endtask

  task automatic t_busy();
    wr(2'd2, 16'h0A08);
    wr(2'd0, 16'h0);
    chk("R8 start", convStart, 1);
    wr(2'd0, 16'h0);
    chk("R11 busy sw", convStart, 0);
    chk("R11 chan held", convChan, 4'd8);
    pulseDone(12'h777);
    chk("R11 first sample", sampleData, 16'h8777);
    chk("R11 advance", convChan, 4'd9);
  endtask

  task automatic t_pacer();
    wr(2'd3, 16'h0002);
    wr(2'd0, 16'h0);
    chk("R8 sw disabled", convStart, 0);
    tick();
    chk("R9 pacer", convStart, 1);
    tick();
    chk("R11 busy tick", convStart, 0);
    pulseDone(12'h123);
    wr(2'd3, 16'h000A);
    extGate = 1'b0;
    tick();
    chk("R9 gate low", convStart, 0);
    extGate = 1'b1;
    tick();
    chk("R9 gate high", convStart, 1);
    pulseDone(12'h124);
    extGate = 1'b0;
  endtask

  task automatic t_ext();
    wr(2'd3, 16'h0004);
    @(negedge clk); extTrig = 1'b1;
    @(negedge clk);
    chk("R10 edge", convStart, 1);
    pulseDone(12'h321);
    @(negedge clk); @(negedge clk);
    chk("R10 held high", convStart, 0);
    extTrig = 1'b0;
    @(negedge clk); extTrig = 1'b1;
    @(negedge clk);
    chk("R10 second edge", convStart, 1);
    pulseDone(12'h322);
    extTrig = 1'b0;
    wr(2'd3, 16'h0001);
    @(negedge clk); extTrig = 1'b1;
    @(negedge clk);
    chk("R10 disabled", convStart, 0);
    extTrig = 1'b0;
  endtask

  task automatic t_clk();
    wr(2'd3, 16'h0041);
    chk("R12 external", pacerExtClk, 1);
    wr(2'd3, 16'h0001);
    chk("R12 internal", pacerExtClk, 0);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mux();
    t_range();
    t_scan();
    t_diff();
    t_busy();
    t_pacer();
    t_ext();
    t_clk();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule